// File: doc/BRIEF.md
# Paired-Register Destination Address Filter

This block decides whether an incoming 48-bit destination address is wanted. It keeps four exact-match address filters and one 64-bit hash filter. Each filter is loaded through two 32-bit register writes, a low word and a high word. The address to test arrives as one parallel word with a single-cycle valid strobe. One cycle later the block reports which exact filters hit and whether the hash filter hit.

Rewriting a filter is atomic without any lock. Loading the low word takes that filter out of service. Loading the high word puts it back in service, now holding the complete new value. A lookup therefore never uses an address that is half old and half new. Writes are accepted at any time, including while lookups are in progress.

Top module: `addr_pair_filter`

## Requirements
- R1: After reset, matchValid, specMatch and hashMatch are 0. No exact filter is in service, so a lookup of the all-zero address gives specMatch = 0 even though the stored words are zero.
- R2: Register index 2k (k = 0..3) loads the low word of exact filter k, which is address bits 31:0. Index 2k+1 loads its high word: wrData bits 15:0 become address bits 47:32, and wrData bits 31:16 are ignored. Index 8 loads hash bits 31:0 and index 9 loads hash bits 63:32.
- R3: A write of the low word of exact filter k takes filter k out of service from the next edge, so later lookups give specMatch[k] = 0.
- R4: A write of the high word of exact filter k puts filter k back in service, now comparing against the full stored 48-bit value.
- R5: specMatch[k] is 1 exactly when filter k is in service and daAddr equals its stored address. Several bits may be 1 for the same lookup.
- R6: The hash index is the XOR of the eight 6-bit slices daAddr[6i+5:6i]. hashMatch is 1 only when hashEn is high during the strobe, the hash filter is in service, and the hash bit at that index is 1.
- R7: The hash filter is in service at reset, with all 64 bits zero. A write to index 8 takes it out of service and a write to index 9 puts it back.
- R8: The outputs are registered. After a cycle with daValid high, matchValid is 1 and the match outputs are valid. After a cycle with daValid low, all three outputs are 0.
- R9: A lookup in the same cycle as a register write uses the filter state as it stood before that write.
- R10: Writes to indices 10 to 15 have no effect on any filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register index |
| wrData | input | 32 | Register write data |
| daValid | input | 1 | Lookup strobe |
| daAddr | input | 48 | Destination address to test |
| hashEn | input | 1 | Allows the hash filter for this lookup |
| specMatch | output | 4 | Per-filter exact match flags |
| hashMatch | output | 1 | Hash filter hit |
| matchValid | output | 1 | Outputs hold a lookup result |

## Verification
The hardest case to reach from the ports is a lookup that lands between the two halves of an update, or in the same cycle as one of the writes. It exposes whether disarming takes effect at the right edge. The bench sequences a low-word write, then a lookup of both the old and the new address, then the high-word write and a lookup again. It also drives a write and a lookup in one cycle. Near-miss addresses that differ only in the high or only in the low half show whether all 48 bits are compared.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int SPEC_PAIRS = 4;
  localparam int PAIRS      = SPEC_PAIRS + 1;
  localparam int HASH_SLOT  = SPEC_PAIRS;

  typedef struct packed {
    logic [PAIRS-1:0] loadBot;
    logic [PAIRS-1:0] loadTop;
    logic             sample;
  } ctrlStrobes_t;
endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             daValid,
  output ctrlStrobes_t     strb
);
  always_comb begin
    strb = '0;
    strb.sample = daValid;
    for (int p = 0; p < PAIRS; p++) begin
      if (wrEn && wrIdx == IDX_W'(2 * p))     strb.loadBot[p] = 1'b1;
      if (wrEn && wrIdx == IDX_W'(2 * p + 1)) strb.loadTop[p] = 1'b1;
    end
  end
endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32,
  parameter int HASH_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     daAddr,
  input  logic                  hashEn,
  output logic [SPEC_PAIRS-1:0] specMatch,
  output logic                  hashMatch,
  output logic                  matchValid
);
  localparam int TOP_W   = ADDR_W - DATA_W;
  localparam int HIDX_W  = $clog2(HASH_W);
  localparam int SLICES  = (ADDR_W + HIDX_W - 1) / HIDX_W;
  localparam int PAD_W   = SLICES * HIDX_W;
  localparam int HHI_W   = HASH_W - DATA_W;

  logic [SPEC_PAIRS-1:0] hit;

  for (genvar g = 0; g < SPEC_PAIRS; g++) begin : g_spec
    logic [DATA_W-1:0] botWord;
    logic [TOP_W-1:0]  topWord;
    logic              armed;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        botWord <= '0;
        topWord <= '0;
        armed   <= 1'b0;
      end else if (strb.loadBot[g]) begin
        botWord <= wrData;
        armed   <= 1'b0;
      end else if (strb.loadTop[g]) begin
        topWord <= wrData[TOP_W-1:0];
        armed   <= 1'b1;
      end
    end

    assign hit[g] = armed && (daAddr == {topWord, botWord});
  end

  logic [DATA_W-1:0] hashLo;
  logic [HHI_W-1:0]  hashHi;
  logic              hashArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hashLo    <= '0;
      hashHi    <= '0;
      hashArmed <= 1'b1;
    end else if (strb.loadBot[HASH_SLOT]) begin
      hashLo    <= wrData;
      hashArmed <= 1'b0;
    end else if (strb.loadTop[HASH_SLOT]) begin
      hashHi    <= wrData[HHI_W-1:0];
      hashArmed <= 1'b1;
    end
  end

  logic [PAD_W-1:0]  padded;
  logic [HIDX_W-1:0] hIdx;
  logic [HASH_W-1:0] hashVec;

  assign padded  = PAD_W'(daAddr);
  assign hashVec = {hashHi, hashLo};

  always_comb begin
    hIdx = '0;
    for (int s = 0; s < SLICES; s++) hIdx ^= padded[s*HIDX_W +: HIDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specMatch  <= '0;
      hashMatch  <= 1'b0;
      matchValid <= 1'b0;
    end else begin
      matchValid <= strb.sample;
      specMatch  <= strb.sample ? hit : '0;
      hashMatch  <= strb.sample && hashEn && hashArmed && hashVec[hIdx];
    end
  end
endmodule

// File: rtl/addr_pair_filter.sv
module addr_pair_filter
  import addr_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32,
  parameter int HASH_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  daValid,
  input  logic [ADDR_W-1:0]     daAddr,
  input  logic                  hashEn,
  output logic [SPEC_PAIRS-1:0] specMatch,
  output logic                  hashMatch,
  output logic                  matchValid
);
  ctrlStrobes_t strb;

  addr_filter_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .daValid(daValid), .strb(strb)
  );

  addr_filter_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HASH_W(HASH_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .daAddr(daAddr),
    .hashEn(hashEn), .specMatch(specMatch), .hashMatch(hashMatch),
    .matchValid(matchValid)
  );
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk
  import addr_filter_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [IDX_W-1:0]      wrIdx,
  input logic                  daValid,
  input logic                  hashEn,
  input logic [SPEC_PAIRS-1:0] specMatch,
  input logic                  hashMatch,
  input logic                  matchValid
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    daValid |=> matchValid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !daValid |=> (specMatch == '0 && !hashMatch && !matchValid));

  a_r6_hash_gated: assert property (@(posedge clk) disable iff (!rstN)
    (daValid && !hashEn) |=> !hashMatch);

  a_r7_hash_bottom_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_W'(2 * HASH_SLOT)) ##1 daValid |=> !hashMatch);

  for (genvar k = 0; k < SPEC_PAIRS; k++) begin : g_chk
    a_r3_bottom_disarms: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrIdx == IDX_W'(2 * k)) ##1 daValid |=> !specMatch[k]);
  end
endmodule

bind addr_pair_filter addr_filter_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .daValid(daValid),
  .hashEn(hashEn), .specMatch(specMatch), .hashMatch(hashMatch),
  .matchValid(matchValid)
);

// File: tb/test_addr_pair_filter.sv
module test_addr_pair_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        daValid = 1'b0;
  logic [47:0] daAddr = '0;
  logic        hashEn = 1'b0;
  logic [3:0]  specMatch;
  logic        hashMatch;
  logic        matchValid;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  addr_pair_filter i_addr_pair_filter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .daValid(daValid), .daAddr(daAddr), .hashEn(hashEn),
    .specMatch(specMatch), .hashMatch(hashMatch), .matchValid(matchValid)
  );

  // {addr, hashEn, expected specMatch, expected hashMatch}
  localparam int NV = 10;
  localparam logic [53:0] VEC [NV] = '{
    {48'h001122334455, 1'b0, 4'b0101, 1'b0},  // R5 two filters share one address
    {48'hA1B2C3D4E5F6, 1'b0, 4'b0010, 1'b0},  // R2 high word bits 31:16 ignored
    {48'hFFFFFFFFFFFF, 1'b0, 4'b1000, 1'b0},
    {48'h001122334454, 1'b0, 4'b0000, 1'b0},  // R5 low half differs
    {48'h011122334455, 1'b0, 4'b0000, 1'b0},  // R5 high half differs
    {48'h000000000000, 1'b1, 4'b0000, 1'b1},  // R6 index 0
    {48'h00000000003F, 1'b1, 4'b0000, 1'b1},  // R6 index 63
    {48'h000000000FC1, 1'b1, 4'b0000, 1'b0},  // R6 index 62 clear
    {48'h040000000001, 1'b1, 4'b0000, 1'b1},  // R6 slices 7 and 0 cancel
    {48'h040000000001, 1'b0, 4'b0000, 1'b0}   // R6 hashEn low
  };

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {matchValid, specMatch, hashMatch};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] a, input logic en);
    @(negedge clk);
    daValid = 1'b1; daAddr = a; hashEn = en;
    @(posedge clk);
    @(negedge clk);
    daValid = 1'b0; hashEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", 6'b0_0000_0);
    lookup(48'h0, 1'b0);
    check("R1 filters out of service at reset", 6'b1_0000_0);
    lookup(48'h0, 1'b1);
    check("R7 hash zero at reset", 6'b1_0000_0);
    @(negedge clk);
    check("R8 idle cycle quiet", 6'b0_0000_0);

    regWrite(4'd0, 32'h22334455); regWrite(4'd1, 32'h00000011);
    regWrite(4'd2, 32'hC3D4E5F6); regWrite(4'd3, 32'hDEADA1B2);
    regWrite(4'd4, 32'h22334455); regWrite(4'd5, 32'h00000011);
    regWrite(4'd6, 32'hFFFFFFFF); regWrite(4'd7, 32'h0000FFFF);
    regWrite(4'd8, 32'h00000001); regWrite(4'd9, 32'h80000000);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][53:6], VEC[i][5]);
      check($sformatf("R5/R6 vector %0d", i), {1'b1, VEC[i][4:0]});
    end

    // R3 / R4: split update of filter 1
    regWrite(4'd2, 32'h11111111);
    lookup(48'hA1B2C3D4E5F6, 1'b0);
    check("R3 old address after low write", 6'b1_0000_0);
    lookup(48'hA1B211111111, 1'b0);
    check("R3 new address before high write", 6'b1_0000_0);
    regWrite(4'd3, 32'h0000A1B2);
    lookup(48'hA1B211111111, 1'b0);
    check("R4 new address after high write", 6'b1_0010_0);

    // R7: hash pair disarm and rearm
    regWrite(4'd8, 32'h00000001);
    lookup(48'h0, 1'b1);
    check("R7 hash out of service", 6'b1_0000_0);
    regWrite(4'd9, 32'h80000000);
    lookup(48'h0, 1'b1);
    check("R7 hash back in service", 6'b1_0000_1);

    // R9: write and lookup in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd0; wrData = 32'h0;
    daValid = 1'b1; daAddr = 48'h001122334455;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; daValid = 1'b0;
    check("R9 same-cycle lookup sees old state", 6'b1_0101_0);
    lookup(48'h001122334455, 1'b0);
    check("R9 following lookup sees disarm", 6'b1_0100_0);

    // R10: unused indices
    for (int j = 10; j < 16; j++) regWrite(4'(j), 32'hFFFFFFFF);
    lookup(48'h001122334455, 1'b0);
    check("R10 unused index leaves filters", 6'b1_0100_0);
    lookup(48'h00000000003F, 1'b1);
    check("R10 unused index leaves hash", 6'b1_0000_1);
    lookup(48'h000000000FC1, 1'b1);
    check("R10 hash bit 62 still clear", 6'b1_0000_0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule